// File: doc/BRIEF.md
# UART Register File

This block is the processor-facing register set of an asynchronous serial port that carries 8-bit or 9-bit characters. It holds the receive and transmit data bytes, two control registers and a status register, and it raises one interrupt line. The transmit and receive shift engines sit outside the block. They report their events to it on single-cycle strobes: a byte handed to the transmit shifter, the transmitter going quiet, a character received (with its ninth bit, noise and framing indications), and an idle line.

Software clears the status flags with a two-step access. It first reads the status register while the flag is set. It then reads the data register to clear the receive-side flags, or writes it to clear the transmit-side flags. Any other access in between cancels the pending clear. The interrupt request is the registered OR of each flag gated by its enable.

Top module: `uart_regfile`

## Requirements
- R1: After reset the status byte reads 0xC0 (only the two transmit flags set), control register 2 reads 0x00, and `irq` is low.
- R2: Address map: 0 = data (a read returns the received byte, a write loads `tx_data`), 1 = control 1 (bit0 received ninth bit, read-only; bit1 transmit ninth bit; bit2 9-bit mode; bit3 address-mark wakeup; bits 7..4 read 0), 2 = control 2 (bit0 transmit-empty IE, bit1 transmit-complete IE, bit2 receive IE, bit3 idle IE, bit4 transmit enable, bit5 receive enable, bit6 standby, bit7 break), 3 = status (bit7 transmit empty, bit6 transmit complete, bit5 receive full, bit4 idle, bit3 overrun, bit2 noise, bit1 framing error, bit0 reads 0). Writable fields read back as written and drive the matching outputs.
- R3: `tx_load_ev` sets transmit-empty and `tx_idle_ev` sets transmit-complete. Both clear when a status read that sees them set is followed by a data write.
- R4: The receive-full, idle, overrun, noise and framing flags clear when a status read that sees them set is followed by a data read.
- R5: An access of any other kind between the status read and the second step cancels the clear. A flag that was clear at the status read is not cleared by the second step.
- R6: An accepted character whose receive-full flag is clear is stored in the data register, its ninth bit appears in control 1 bit0, and receive-full is set, along with noise and framing error when the engine flags them.
- R7: A character that arrives while receive-full is set sets overrun only. The stored byte is kept, the new one is discarded, and neither framing error nor noise is set.
- R8: With receive enable at 0, received-character and idle strobes are ignored, existing receive flags stay as they are, and the receive and idle flags do not drive `irq`.
- R9: `irq` is high one cycle after any flag and its enable are both high: transmit-empty with bit0, transmit-complete with bit1, receive-full or overrun with bit2, idle with bit3.
- R10: When a flag's setting event and its clearing second step fall in the same cycle, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 2 | Register address |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the cycle of `bus_rd`, 0 otherwise |
| tx_load_ev | input | 1 | Transmit byte moved into the shifter |
| tx_idle_ev | input | 1 | Transmitter has nothing left to send |
| rx_done_ev | input | 1 | Character received |
| rx_word | input | 8 | Received low eight bits |
| rx_bit8 | input | 1 | Received ninth bit |
| rx_noise | input | 1 | Noise seen in the received character |
| rx_ferr | input | 1 | Stop bit sampled low |
| rx_idle_ev | input | 1 | Idle line detected |
| tx_data | output | 8 | Transmit byte for the shifter |
| tx_bit8 | output | 1 | Transmit ninth bit |
| char9 | output | 1 | 9-bit character mode |
| wake_addr | output | 1 | Wakeup on address mark (0 = idle line) |
| tx_en | output | 1 | Transmitter enable |
| rx_en | output | 1 | Receiver enable |
| rx_standby | output | 1 | Receiver standby |
| send_break | output | 1 | Send break |
| irq | output | 1 | Registered interrupt request |

## Verification
The assertions assume that the bus issues at most one access per cycle and never asserts read and write together. They also assume that the engine strobes are single-cycle pulses whose data inputs are valid in the strobe cycle. The bench drives every access as a one-cycle strobe on the falling edge and pulses each engine event for exactly one cycle. It combines a bus access with an event strobe only in the same-cycle priority scenario, where both are meant to meet.

// File: rtl/uart_regs_pkg.sv
package uart_regs_pkg;

    localparam int DATA_W  = 8;
    localparam int ADDR_W  = 2;
    localparam int IRQ_SRC = 4;

    typedef enum logic [ADDR_W-1:0] {
        A_DATA  = 2'd0,
        A_CTRL1 = 2'd1,
        A_CTRL2 = 2'd2,
        A_STAT  = 2'd3
    } reg_addr_e;

    // Field order fixes the status byte bits 7..1.
    typedef struct packed {
        logic tx_empty;
        logic tx_done;
        logic rx_full;
        logic rx_idle;
        logic overrun;
        logic noise;
        logic frame_err;
    } stat_t;

    // Field order fixes the control-2 byte bits 7..0.
    typedef struct packed {
        logic brk;
        logic standby;
        logic rx_en;
        logic tx_en;
        logic idle_ie;
        logic rx_ie;
        logic txc_ie;
        logic tx_ie;
    } ctrl2_t;

    typedef struct packed {
        logic wake_addr;
        logic char9;
        logic tx9;
    } ctrl1_t;

    localparam stat_t STAT_RST = '{tx_empty: 1'b1, tx_done: 1'b1, default: 1'b0};

    function automatic logic [DATA_W-1:0] stat_byte(input stat_t s);
        return {s, 1'b0};
    endfunction

    function automatic logic [DATA_W-1:0] ctrl1_byte(input ctrl1_t c, input logic rx9);
        return {4'b0000, c, rx9};
    endfunction

endpackage

// File: rtl/uart_ctrl_regs.sv
module uart_ctrl_regs
    import uart_regs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_ctrl1,
    input  logic              wr_ctrl2,
    input  logic              wr_data,
    input  logic [DATA_W-1:0] wdata,
    output ctrl1_t            c1,
    output ctrl2_t            c2,
    output logic [DATA_W-1:0] tx_data
);

    always_ff @(posedge clk) begin
        if (rst) begin
            c1      <= '0;
            c2      <= '0;
            tx_data <= '0;
        end else begin
            if (wr_ctrl1) c1 <= ctrl1_t'(wdata[3:1]);
            if (wr_ctrl2) c2 <= ctrl2_t'(wdata);
            if (wr_data)  tx_data <= wdata;
        end
    end

    p_ctrl2_wr_r2: assert property (@(posedge clk) disable iff (rst)
        wr_ctrl2 |=> c2 == $past(wdata));

endmodule

// File: rtl/uart_stat_flags.sv
module uart_stat_flags
    import uart_regs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              st_rd,
    input  logic              dat_rd,
    input  logic              dat_wr,
    input  logic              any_acc,
    input  logic              rx_en,
    input  logic              tx_load_ev,
    input  logic              tx_idle_ev,
    input  logic              rx_done_ev,
    input  logic [DATA_W-1:0] rx_word,
    input  logic              rx_bit8,
    input  logic              rx_noise,
    input  logic              rx_ferr,
    input  logic              rx_idle_ev,
    output stat_t             flags,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx9
);

    stat_t arm;
    stat_t clr;
    stat_t set;
    stat_t flags_n;
    logic  full_eff;
    logic  rx_take;
    logic  store;
    logic  ovr;

    always_comb begin
        clr           = '0;
        clr.tx_empty  = dat_wr & arm.tx_empty;
        clr.tx_done   = dat_wr & arm.tx_done;
        clr.rx_full   = dat_rd & arm.rx_full;
        clr.rx_idle   = dat_rd & arm.rx_idle;
        clr.overrun   = dat_rd & arm.overrun;
        clr.noise     = dat_rd & arm.noise;
        clr.frame_err = dat_rd & arm.frame_err;

        full_eff = flags.rx_full & ~clr.rx_full;
        rx_take  = rx_done_ev & rx_en;
        store    = rx_take & ~full_eff;
        ovr      = rx_take & full_eff;

        set           = '0;
        set.tx_empty  = tx_load_ev;
        set.tx_done   = tx_idle_ev;
        set.rx_full   = store;
        set.rx_idle   = rx_idle_ev & rx_en;
        set.overrun   = ovr;
        set.noise     = store & rx_noise;
        set.frame_err = store & rx_ferr;

        flags_n = (flags & ~clr) | set;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flags   <= STAT_RST;
            arm     <= '0;
            rx_data <= '0;
            rx9     <= 1'b0;
        end else begin
            flags <= flags_n;
            if (st_rd)        arm <= flags;
            else if (any_acc) arm <= '0;
            if (store) begin
                rx_data <= rx_word;
                rx9     <= rx_bit8;
            end
        end
    end

    p_ovr_keeps_data_r7: assert property (@(posedge clk) disable iff (rst)
        (rx_done_ev && rx_en && flags.rx_full && !dat_rd) |=> ($stable(rx_data) && flags.overrun));

    p_ovr_no_ferr_r7: assert property (@(posedge clk) disable iff (rst)
        (rx_done_ev && rx_en && flags.rx_full && !dat_rd && !flags.frame_err) |=> !flags.frame_err);

    p_rx_off_r8: assert property (@(posedge clk) disable iff (rst)
        !rx_en |=> (!$rose(flags.rx_full) && !$rose(flags.rx_idle)));

    p_txe_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (flags.tx_empty && !dat_wr) |=> flags.tx_empty);

    p_rxf_fall_r4: assert property (@(posedge clk) disable iff (rst)
        $fell(flags.rx_full) |-> $past(dat_rd));

endmodule

// File: rtl/uart_irq_gen.sv
module uart_irq_gen
    import uart_regs_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  stat_t  flags,
    input  ctrl2_t c2,
    output logic   irq
);

    logic [IRQ_SRC-1:0] src;
    logic [IRQ_SRC-1:0] ena;
    logic [IRQ_SRC-1:0] hit;

    always_comb begin
        src[0] = flags.tx_empty;
        src[1] = flags.tx_done;
        src[2] = flags.rx_full | flags.overrun;
        src[3] = flags.rx_idle;
        ena[0] = c2.tx_ie;
        ena[1] = c2.txc_ie;
        ena[2] = c2.rx_ie   & c2.rx_en;
        ena[3] = c2.idle_ie & c2.rx_en;
    end

    for (genvar i = 0; i < IRQ_SRC; i++) begin : g_src
        assign hit[i] = src[i] & ena[i];
    end

    always_ff @(posedge clk) begin
        if (rst) irq <= 1'b0;
        else     irq <= |hit;
    end

    p_irq_reset_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !irq);

    p_irq_masked_r9: assert property (@(posedge clk) disable iff (rst)
        ($past(c2.tx_ie) == 1'b0 && $past(c2.txc_ie) == 1'b0 &&
         $past(c2.rx_ie) == 1'b0 && $past(c2.idle_ie) == 1'b0) |-> !irq);

endmodule

// File: rtl/uart_regfile.sv
module uart_regfile
    import uart_regs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              tx_load_ev,
    input  logic              tx_idle_ev,
    input  logic              rx_done_ev,
    input  logic [DATA_W-1:0] rx_word,
    input  logic              rx_bit8,
    input  logic              rx_noise,
    input  logic              rx_ferr,
    input  logic              rx_idle_ev,
    output logic [DATA_W-1:0] tx_data,
    output logic              tx_bit8,
    output logic              char9,
    output logic              wake_addr,
    output logic              tx_en,
    output logic              rx_en,
    output logic              rx_standby,
    output logic              send_break,
    output logic              irq
);

    reg_addr_e         sel;
    ctrl1_t            c1;
    ctrl2_t            c2;
    stat_t             flags;
    logic [DATA_W-1:0] rx_data;
    logic              rx9;
    logic              st_rd;
    logic              dat_rd;
    logic              dat_wr;
    logic              any_acc;

    assign sel     = reg_addr_e'(bus_addr);
    assign st_rd   = bus_rd & (sel == A_STAT);
    assign dat_rd  = bus_rd & (sel == A_DATA);
    assign dat_wr  = bus_wr & (sel == A_DATA);
    assign any_acc = bus_rd | bus_wr;

    uart_ctrl_regs u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .wr_ctrl1 (bus_wr & (sel == A_CTRL1)),
        .wr_ctrl2 (bus_wr & (sel == A_CTRL2)),
        .wr_data  (dat_wr),
        .wdata    (bus_wdata),
        .c1       (c1),
        .c2       (c2),
        .tx_data  (tx_data)
    );

    uart_stat_flags u_flags (
        .clk        (clk),
        .rst        (rst),
        .st_rd      (st_rd),
        .dat_rd     (dat_rd),
        .dat_wr     (dat_wr),
        .any_acc    (any_acc),
        .rx_en      (c2.rx_en),
        .tx_load_ev (tx_load_ev),
        .tx_idle_ev (tx_idle_ev),
        .rx_done_ev (rx_done_ev),
        .rx_word    (rx_word),
        .rx_bit8    (rx_bit8),
        .rx_noise   (rx_noise),
        .rx_ferr    (rx_ferr),
        .rx_idle_ev (rx_idle_ev),
        .flags      (flags),
        .rx_data    (rx_data),
        .rx9        (rx9)
    );

    uart_irq_gen u_irq (
        .clk   (clk),
        .rst   (rst),
        .flags (flags),
        .c2    (c2),
        .irq   (irq)
    );

    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            unique case (sel)
                A_DATA:  bus_rdata = rx_data;
                A_CTRL1: bus_rdata = ctrl1_byte(c1, rx9);
                A_CTRL2: bus_rdata = c2;
                A_STAT:  bus_rdata = stat_byte(flags);
                default: bus_rdata = '0;
            endcase
        end
    end

    assign tx_bit8    = c1.tx9;
    assign char9      = c1.char9;
    assign wake_addr  = c1.wake_addr;
    assign tx_en      = c2.tx_en;
    assign rx_en      = c2.rx_en;
    assign rx_standby = c2.standby;
    assign send_break = c2.brk;

    p_reset_stat_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (flags == STAT_RST && c2 == '0));

    p_one_access_r2: assert property (@(posedge clk) disable iff (rst)
        !(bus_rd && bus_wr));

endmodule

// File: tb/uart_regfile_test.sv
`timescale 1ns/1ps
module uart_regfile_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] bus_addr = '0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       tx_load_ev = 1'b0, tx_idle_ev = 1'b0, rx_done_ev = 1'b0;
    logic [7:0] rx_word = '0;
    logic       rx_bit8 = 1'b0, rx_noise = 1'b0, rx_ferr = 1'b0, rx_idle_ev = 1'b0;
    logic [7:0] tx_data;
    logic       tx_bit8, char9, wake_addr, tx_en, rx_en, rx_standby, send_break, irq;

    int checks = 0;
    int failures = 0;
    logic [7:0] v;

    always #2.5 clk = ~clk;

    uart_regfile uut (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(posedge clk); #1 bus_rd = 1'b0;
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk); #1 bus_wr = 1'b0;
    endtask

    task automatic rx_char(input logic [7:0] w, input logic b8, input logic nz, input logic fe);
        @(negedge clk);
        rx_word = w; rx_bit8 = b8; rx_noise = nz; rx_ferr = fe; rx_done_ev = 1'b1;
        @(posedge clk); #1 rx_done_ev = 1'b0; rx_noise = 1'b0; rx_ferr = 1'b0;
    endtask

    task automatic pulse_txload();
        @(negedge clk); tx_load_ev = 1'b1; @(posedge clk); #1 tx_load_ev = 1'b0;
    endtask

    task automatic pulse_txidle();
        @(negedge clk); tx_idle_ev = 1'b1; @(posedge clk); #1 tx_idle_ev = 1'b0;
    endtask

    task automatic pulse_rxidle();
        @(negedge clk); rx_idle_ev = 1'b1; @(posedge clk); #1 rx_idle_ev = 1'b0;
    endtask

    task automatic clear_rx();
        rd(2'd3, v); rd(2'd0, v);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        rd(2'd3, v); chk("R1 status after reset", v, 8'hC0);
        rd(2'd2, v); chk("R1 ctrl2 after reset", v, 8'h00);
        @(negedge clk); chk("R1 irq after reset", irq, 1'b0);
    endtask

    task automatic t_ctrl();
        wr(2'd2, 8'hC5); rd(2'd2, v); chk("R2 ctrl2 readback", v, 8'hC5);
        @(negedge clk);
        chk("R2 break/standby/rx_en/tx_en outs", {send_break, rx_standby, rx_en, tx_en}, 4'b1100);
        wr(2'd2, 8'h30); @(negedge clk);
        chk("R2 enables out", {rx_en, tx_en}, 2'b11);
        wr(2'd2, 8'h00);
        wr(2'd1, 8'hFE); rd(2'd1, v); chk("R2 ctrl1 readback", v, 8'h0E);
        @(negedge clk);
        chk("R2 ctrl1 outs", {wake_addr, char9, tx_bit8}, 3'b111);
        wr(2'd1, 8'h00);
        wr(2'd0, 8'h3C); @(negedge clk); chk("R2 tx_data", tx_data, 8'h3C);
    endtask

    task automatic t_tx();
        rd(2'd3, v); chk("R3 tx flags set", v & 8'hC0, 8'hC0);
        wr(2'd0, 8'h55);
        rd(2'd3, v); chk("R3 tx flags cleared", v & 8'hC0, 8'h00);
        pulse_txload(); rd(2'd3, v); chk("R3 tx_load sets empty", v & 8'hC0, 8'h80);
        pulse_txidle(); rd(2'd3, v); chk("R3 tx_idle sets done", v & 8'hC0, 8'hC0);
    endtask

    task automatic t_arm();
        rd(2'd3, v); rd(2'd2, v); wr(2'd0, 8'h01);
        rd(2'd3, v); chk("R5 intervening access cancels", v & 8'hC0, 8'hC0);
        wr(2'd0, 8'h02);
        rd(2'd3, v); chk("R5 direct sequence clears", v & 8'hC0, 8'h00);
        pulse_txload();
        wr(2'd0, 8'h03);
        rd(2'd3, v); chk("R5 flag clear at status read not armed", v & 8'hC0, 8'h80);
        wr(2'd0, 8'h04); pulse_txidle(); pulse_txload();
    endtask

    task automatic t_rx();
        wr(2'd2, 8'h20);
        rx_char(8'h5A, 1'b1, 1'b1, 1'b0);
        rd(2'd3, v); chk("R6 rx_full and noise", v & 8'h3E, 8'h24);
        rd(2'd1, v); chk("R6 ninth bit", v & 8'h01, 8'h01);
        rd(2'd0, v); chk("R6 data", v, 8'h5A);
        rd(2'd3, v); chk("R4 flags kept without sequence", v & 8'h3E, 8'h24);
        rd(2'd0, v);
        rd(2'd3, v); chk("R4 rx flags cleared", v & 8'h3E, 8'h00);
        rx_char(8'hA1, 1'b0, 1'b0, 1'b1);
        rd(2'd3, v); chk("R6 framing error", v & 8'h3E, 8'h22);
        rd(2'd1, v); chk("R6 ninth bit zero", v & 8'h01, 8'h00);
        clear_rx();
        pulse_rxidle();
        rd(2'd3, v); chk("R4 idle set", v & 8'h3E, 8'h10);
        rd(2'd0, v);
        rd(2'd3, v); chk("R4 idle cleared", v & 8'h3E, 8'h00);
    endtask

    task automatic t_ovr();
        rx_char(8'h11, 1'b0, 1'b0, 1'b0);
        rx_char(8'h22, 1'b1, 1'b1, 1'b1);
        rd(2'd3, v); chk("R7 overrun only", v & 8'h3E, 8'h28);
        rd(2'd0, v); chk("R7 data kept", v, 8'h11);
        rd(2'd1, v); chk("R7 ninth bit kept", v & 8'h01, 8'h00);
        clear_rx();
        rd(2'd3, v); chk("R4 overrun cleared", v & 8'h3E, 8'h00);
    endtask

    task automatic t_rx_off();
        wr(2'd2, 8'h00);
        rx_char(8'h77, 1'b1, 1'b0, 1'b0);
        pulse_rxidle();
        rd(2'd3, v); chk("R8 events ignored", v & 8'h3E, 8'h00);
        rd(2'd0, v); chk("R8 data unchanged", v, 8'h11);
        wr(2'd2, 8'h24);
        rx_char(8'h66, 1'b0, 1'b0, 1'b0);
        repeat (2) @(negedge clk);
        chk("R9 rx irq", irq, 1'b1);
        wr(2'd2, 8'h04);
        repeat (2) @(negedge clk);
        chk("R8 rx irq masked when disabled", irq, 1'b0);
        rd(2'd3, v); chk("R8 flag kept when disabled", v & 8'h3E, 8'h20);
        clear_rx();
        wr(2'd2, 8'h00);
    endtask

    task automatic t_irq();
        wr(2'd2, 8'h01);
        chk("R9 irq one cycle late", irq, 1'b0);
        @(posedge clk); #1;
        chk("R9 irq on tx empty", irq, 1'b1);
        wr(2'd2, 8'h00); repeat (2) @(negedge clk);
        chk("R9 irq off", irq, 1'b0);
        wr(2'd2, 8'h02); repeat (2) @(negedge clk);
        chk("R9 irq on tx done", irq, 1'b1);
        wr(2'd2, 8'h00);
    endtask

    task automatic t_set_wins();
        rd(2'd3, v);
        @(negedge clk);
        bus_addr = 2'd0; bus_wdata = 8'h99; bus_wr = 1'b1; tx_load_ev = 1'b1;
        @(posedge clk); #1 bus_wr = 1'b0; tx_load_ev = 1'b0;
        rd(2'd3, v); chk("R10 set beats clear", v & 8'hC0, 8'h80);
    endtask

    initial begin
        t_reset();
        t_ctrl();
        t_tx();
        t_arm();
        t_rx();
        t_ovr();
        t_rx_off();
        t_irq();
        t_set_wins();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule